// File: doc/BRIEF.md
# Hash Message Input Formatter

This block takes a message for a block-oriented hash engine one 32-bit word at a time, from processor stores or from short bursts issued by a DMA engine. It reorders the four bytes of each word according to a programmed byte-order mode. It tracks how many message bytes are still expected and groups the words into 16-word message blocks for the hash core. Padding and compression are performed elsewhere. The formatter only delivers the words. It marks the block that carries the final word and reports how many bytes of that word are real.

A message is opened by an arm pulse that samples the byte-order mode and the message length in bits. The byte count is the bit length with its three low bits dropped. The writer has no byte-valid mask. Every word carries four message bytes except the final one, and the number of bytes in the final word follows from the programmed length alone. After an arm, the data port holds off for a fixed settling time. A word offered early is held back by the handshake rather than dropped. The core takes each block through a valid/ready handshake. A completion pulse follows the final block. Writes that reach a message that is already complete are dropped and flagged.

Top module: `hash_msg_formatter`

## Requirements
- R1: After reset, `wr_ready` is 1, `blk_valid`, `msg_done` and `wr_err` are 0, and no message is open.
- R2: After a cycle with `arm`=1 and a non-zero byte count, `wr_ready` is 0 for the next SETTLE_CYC (default 2) cycles. A word offered during that time is accepted afterwards, and none of its content is lost.
- R3: Input bytes are named b3..b0 from `wr_data[31:24]` down to `wr_data[7:0]`. The stored word, most significant byte first, is: `cfg_order`=0 → b3 b2 b1 b0; 1 → b0 b1 b2 b3; 2 → b2 b3 b1 b0; 3 → b1 b0 b3 b2.
- R4: The byte count is `cfg_bitlen >> 3`, and the low three bits are ignored. Each accepted word takes up to 4 bytes. The word accepted while 4 or fewer bytes remain is the final word of the message.
- R5: In the final word, only the N most significant bytes of the reordered word are kept, where N is the number of remaining bytes (1..4). The other bytes are forced to 0. `blk_tail_bytes` gives the valid bytes in the last word of a block: 4 for a block that is not last, N for the last block, 0 for an empty block.
- R6: Word k of a block (k=0 first) appears at `blk_data[511-32k -: 32]`, and unused word slots are 0. A block is presented when it holds 16 words or holds the final word. `blk_nwords` gives its word count. `blk_last` is 1 only on the block that holds the final word. While `blk_ready` is 0, `blk_valid` and `blk_data` hold their values.
- R7: `wr_ready` is 0 whenever `blk_valid` is 1. While a block is being filled and the core is not holding one back, words are accepted on consecutive cycles.
- R8: `msg_done` pulses for one cycle, in the cycle after the handshake of the block with `blk_last`=1.
- R9: A write accepted when no message is open, whether after the final word or before the first arm, changes no block. `wr_err` pulses in the next cycle.
- R10: An arm with a byte count of 0 presents, in the next cycle, a block with `blk_last`=1, `blk_nwords`=0 and `blk_tail_bytes`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Opens a new message and samples the configuration |
| cfg_order | input | 2 | Byte-order mode |
| cfg_bitlen | input | LEN_W | Message length in bits |
| wr_valid | input | 1 | Data word offered |
| wr_data | input | 32 | Data word |
| wr_ready | output | 1 | Data word accepted when high with wr_valid |
| wr_err | output | 1 | One-cycle pulse: write arrived with no message open |
| blk_valid | output | 1 | Block presented to the core |
| blk_data | output | BLK_WORDS*32 | Block words, first word most significant |
| blk_last | output | 1 | Block holds the final word |
| blk_nwords | output | NW_W | Number of words in the block |
| blk_tail_bytes | output | 3 | Valid bytes in the block's last word |
| blk_ready | input | 1 | Core accepts the block |
| msg_done | output | 1 | One-cycle pulse after the final block is taken |

## Verification
The bench offers a word in the cycle right after arm. It checks that the two settling cycles pass and that the word still appears in the block. A design that skipped the settle or dropped the early word would shift every later word or lose one. It uses lengths whose low three bits are non-zero and final words with 1, 2 and 3 valid bytes. A design that rounded the count up or masked from the wrong end would produce stray bytes. A 20-word message with the core stalled checks that the first block stays frozen and that input stops, so that a design that overwrote a held block would corrupt it. Zero-length messages and writes after completion cover the case where the final word arrives with no data and the case of writes with no message open.

// File: rtl/hmf_pkg.sv
package hmf_pkg;
  localparam int WORD_W     = 32;
  localparam int WORD_BYTES = WORD_W / 8;

  typedef enum logic [1:0] {
    ORD_KEEP   = 2'd0,
    ORD_REV    = 2'd1,
    ORD_HIGHSW = 2'd2,
    ORD_PAIRSW = 2'd3
  } order_e;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_SETTLE = 3'd1,
    S_FILL   = 3'd2,
    S_SEND   = 3'd3
  } fmt_state_e;
endpackage

// File: rtl/hmf_lane_swap.sv
module hmf_lane_swap
  import hmf_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  order_e            order_i,
  input  logic [2:0]        keep_i,
  output logic [WORD_W-1:0] word_o
);
  logic [7:0]        b3, b2, b1, b0;
  logic [WORD_W-1:0] swapped;

  assign {b3, b2, b1, b0} = word_i;

  always_comb begin
    unique case (order_i)
      ORD_KEEP:   swapped = {b3, b2, b1, b0};
      ORD_REV:    swapped = {b0, b1, b2, b3};
      ORD_HIGHSW: swapped = {b2, b3, b1, b0};
      default:    swapped = {b1, b0, b3, b2};
    endcase
  end

  // Lane g counts from the most significant byte; kept when g < keep_i.
  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    assign word_o[WORD_W-1-8*g -: 8] =
      (3'(g) < keep_i) ? swapped[WORD_W-1-8*g -: 8] : 8'h00;
  end
endmodule

// File: rtl/hmf_len_track.sv
module hmf_len_track #(
  parameter int CNT_W = 61
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] bytes_i,
  input  logic             step_i,
  output logic             final_o,
  output logic [2:0]       keep_o
);
  logic [CNT_W-1:0] rem_q, rem_d;
  logic             le4;

  assign le4     = (rem_q <= CNT_W'(4));
  assign final_o = le4;
  assign keep_o  = le4 ? rem_q[2:0] : 3'd4;

  always_comb begin
    rem_d = rem_q;
    if (load_i) begin
      rem_d = bytes_i;
    end else if (step_i) begin
      rem_d = le4 ? '0 : rem_q - CNT_W'(4);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (load_i || step_i) begin
      rem_q <= rem_d;
    end
  end
endmodule

// File: rtl/hmf_block_pack.sv
module hmf_block_pack
  import hmf_pkg::*;
#(
  parameter int BLK_WORDS = 16,
  parameter int NW_W      = $clog2(BLK_WORDS + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear_i,
  input  logic                        seal_i,
  input  logic                        wr_i,
  input  logic [WORD_W-1:0]           word_i,
  input  logic [2:0]                  tail_i,
  input  logic                        last_i,
  output logic [BLK_WORDS*WORD_W-1:0] data_o,
  output logic [NW_W-1:0]             nwords_o,
  output logic [2:0]                  tail_o,
  output logic                        last_o,
  output logic                        near_full_o
);
  logic [NW_W-1:0] cnt_q, cnt_d;
  logic [2:0]      tail_q, tail_d;
  logic            last_q, last_d;

  for (genvar g = 0; g < BLK_WORDS; g++) begin : g_slot
    logic [WORD_W-1:0] slot_q;
    logic              slot_en;
    assign slot_en = clear_i || (wr_i && (cnt_q == NW_W'(g)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (slot_en) begin
        slot_q <= clear_i ? '0 : word_i;
      end
    end
    assign data_o[BLK_WORDS*WORD_W-1-WORD_W*g -: WORD_W] = slot_q;
  end

  always_comb begin
    cnt_d  = cnt_q;
    tail_d = tail_q;
    last_d = last_q;
    if (clear_i) begin
      cnt_d  = '0;
      tail_d = 3'd0;
      last_d = seal_i;
    end else if (wr_i) begin
      cnt_d  = cnt_q + NW_W'(1);
      tail_d = tail_i;
      last_d = last_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tail_q <= 3'd0;
      last_q <= 1'b0;
    end else if (clear_i || wr_i) begin
      cnt_q  <= cnt_d;
      tail_q <= tail_d;
      last_q <= last_d;
    end
  end

  assign nwords_o    = cnt_q;
  assign tail_o      = tail_q;
  assign last_o      = last_q;
  assign near_full_o = (cnt_q == NW_W'(BLK_WORDS - 1));
endmodule

// File: rtl/hash_msg_formatter.sv
module hash_msg_formatter
  import hmf_pkg::*;
#(
  parameter int LEN_W      = 64,
  parameter int BLK_WORDS  = 16,
  parameter int SETTLE_CYC = 2,
  localparam int NW_W      = $clog2(BLK_WORDS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    arm,
  input  logic [1:0]              cfg_order,
  input  logic [LEN_W-1:0]        cfg_bitlen,
  input  logic                    wr_valid,
  input  logic [31:0]             wr_data,
  output logic                    wr_ready,
  output logic                    wr_err,
  output logic                    blk_valid,
  output logic [BLK_WORDS*32-1:0] blk_data,
  output logic                    blk_last,
  output logic [NW_W-1:0]         blk_nwords,
  output logic [2:0]              blk_tail_bytes,
  input  logic                    blk_ready,
  output logic                    msg_done
);
  localparam int CNT_W = LEN_W - 3;
  localparam int SC_W  = $clog2(SETTLE_CYC + 1);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  fmt_state_e       state_q, state_d;
  logic [SC_W-1:0]  settle_q, settle_d;
  order_e           order_q;
  logic             done_q, err_q;

  logic [CNT_W-1:0]  cfg_bytes;
  logic              cfg_zero;
  logic              wr_fire, take, stray, blk_fire;
  logic              is_final, near_full;
  logic [2:0]        keep;
  logic [WORD_W-1:0] word_fmt;
  logic              unused_lowbits;

  assign cfg_bytes      = cfg_bitlen[LEN_W-1:3];
  assign unused_lowbits = ^cfg_bitlen[2:0];
  assign cfg_zero       = (cfg_bytes == '0);

  assign wr_ready  = (state_q == S_IDLE) || (state_q == S_FILL);
  assign blk_valid = (state_q == S_SEND);
  assign wr_fire   = wr_valid && wr_ready;
  assign take      = wr_fire && (state_q == S_FILL) && !arm;
  assign stray     = wr_fire && (state_q == S_IDLE) && !arm;
  assign blk_fire  = blk_valid && blk_ready;

  hmf_lane_swap u_swap (
    .word_i  (wr_data),
    .order_i (order_q),
    .keep_i  (keep),
    .word_o  (word_fmt)
  );

  hmf_len_track #(.CNT_W(CNT_W)) u_len (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load_i  (arm),
    .bytes_i (cfg_bytes),
    .step_i  (take),
    .final_o (is_final),
    .keep_o  (keep)
  );

  hmf_block_pack #(.BLK_WORDS(BLK_WORDS), .NW_W(NW_W)) u_pack (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .clear_i     (arm || blk_fire),
    .seal_i      (arm && cfg_zero),
    .wr_i        (take),
    .word_i      (word_fmt),
    .tail_i      (keep),
    .last_i      (is_final),
    .data_o      (blk_data),
    .nwords_o    (blk_nwords),
    .tail_o      (blk_tail_bytes),
    .last_o      (blk_last),
    .near_full_o (near_full)
  );

  // Next state
  always_comb begin
    state_d  = state_q;
    settle_d = settle_q;
    if (arm) begin
      state_d  = cfg_zero ? S_SEND : S_SETTLE;
      settle_d = SC_W'(SETTLE_CYC - 1);
    end else begin
      unique case (state_q)
        S_SETTLE: begin
          if (settle_q == '0) state_d = S_FILL;
          else                settle_d = settle_q - SC_W'(1);
        end
        S_FILL: begin
          if (take && (is_final || near_full)) state_d = S_SEND;
        end
        S_SEND: begin
          if (blk_ready) state_d = blk_last ? S_IDLE : S_FILL;
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q  <= S_IDLE;
      settle_q <= '0;
    end else begin
      state_q  <= state_d;
      settle_q <= settle_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      order_q <= ORD_KEEP;
    end else if (arm) begin
      order_q <= order_e'(cfg_order);
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= blk_fire && blk_last && !arm;
      err_q  <= stray;
    end
  end

  assign msg_done = done_q;
  assign wr_err   = err_q;
endmodule

// File: rtl/hmf_checker.sv
module hmf_checker #(
  parameter int LEN_W     = 64,
  parameter int BLK_WORDS = 16,
  parameter int NW_W      = $clog2(BLK_WORDS + 1)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    arm,
  input logic [1:0]              cfg_order,
  input logic [LEN_W-1:0]        cfg_bitlen,
  input logic                    wr_valid,
  input logic [31:0]             wr_data,
  input logic                    wr_ready,
  input logic                    wr_err,
  input logic                    blk_valid,
  input logic [BLK_WORDS*32-1:0] blk_data,
  input logic                    blk_last,
  input logic [NW_W-1:0]         blk_nwords,
  input logic [2:0]              blk_tail_bytes,
  input logic                    blk_ready,
  input logic                    msg_done
);
  logic nz_arm;
  logic unused_chk;
  assign nz_arm     = arm && (cfg_bitlen[LEN_W-1:3] != '0);
  assign unused_chk = ^{cfg_order, wr_data};

  // R2: settling gap after an arm
  a_r2_gap_first: assert property (@(posedge clk) disable iff (!rst_n)
    nz_arm |=> !wr_ready);
  a_r2_gap_second: assert property (@(posedge clk) disable iff (!rst_n)
    nz_arm |=> ##1 !wr_ready);

  // R6: a held block does not change
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && !blk_ready && !arm) |=> (blk_valid && $stable(blk_data)));

  // R6: block size bounded
  a_r6_nwords: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid |-> (blk_nwords <= NW_W'(BLK_WORDS)));

  // R5: tail byte count range
  a_r5_tail: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid |-> (blk_tail_bytes <= 3'd4));

  // R7: input stalls while a block waits
  a_r7_stall: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid |-> !wr_ready);

  // R8: completion follows the last block handshake
  a_r8_done: assert property (@(posedge clk) disable iff (!rst_n)
    msg_done |-> $past(blk_valid && blk_ready && blk_last));

  // R9: error pulse only after an accepted write
  a_r9_err: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(wr_valid && wr_ready));

  // R10: zero-length arm gives an empty final block
  a_r10_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && (cfg_bitlen[LEN_W-1:3] == '0)) |=>
      (blk_valid && blk_last && (blk_nwords == '0) && (blk_tail_bytes == 3'd0)));
endmodule

bind hash_msg_formatter hmf_checker #(
  .LEN_W(LEN_W), .BLK_WORDS(BLK_WORDS), .NW_W(NW_W)
) u_hmf_checker (.*);

// File: tb/hash_msg_formatter_test.sv
module hash_msg_formatter_test;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 64;
  localparam int BW    = 16;
  localparam int NW_W  = $clog2(BW + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              arm = 1'b0;
  logic [1:0]        cfg_order = 2'd0;
  logic [LEN_W-1:0]  cfg_bitlen = '0;
  logic              wr_valid = 1'b0;
  logic [31:0]       wr_data = '0;
  logic              wr_ready, wr_err, blk_valid, blk_last, msg_done;
  logic [BW*32-1:0]  blk_data;
  logic [NW_W-1:0]   blk_nwords;
  logic [2:0]        blk_tail_bytes;
  logic              blk_ready = 1'b1;

  int checks = 0;
  int errors = 0;
  int err_seen = 0;
  int blocks_seen = 0;
  int done_seen = 0;

  logic [BW*32-1:0] q_data[$];
  int               q_nw[$];
  int               q_tail[$];
  bit               q_last[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  hash_msg_formatter #(.LEN_W(LEN_W), .BLK_WORDS(BW), .SETTLE_CYC(2)) uut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .cfg_order(cfg_order),
    .cfg_bitlen(cfg_bitlen), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .wr_err(wr_err), .blk_valid(blk_valid),
    .blk_data(blk_data), .blk_last(blk_last), .blk_nwords(blk_nwords),
    .blk_tail_bytes(blk_tail_bytes), .blk_ready(blk_ready), .msg_done(msg_done)
  );

  task automatic chk(input bit ok, input string req, input logic [511:0] act,
                     input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_fmt(input logic [31:0] w, input int mode,
                                          input int keep);
    logic [7:0] b[4];
    logic [31:0] r;
    for (int k = 0; k < 4; k++) b[k] = w[8*k +: 8];
    case (mode)
      0: r = {b[3], b[2], b[1], b[0]};
      1: r = {b[0], b[1], b[2], b[3]};
      2: r = {b[2], b[3], b[1], b[0]};
      default: r = {b[1], b[0], b[3], b[2]};
    endcase
    for (int k = 0; k < 4; k++) if (k >= keep) r[31-8*k -: 8] = 8'h00;
    return r;
  endfunction

  function automatic logic [31:0] gen_word(input int i, input int seed);
    return 32'hA51C_3E70 ^ (i * 32'h0103_0507) ^ (seed * 32'h1111_0000);
  endfunction

  // Monitor: block contents, hold, stall, completion and error pulses
  logic             prev_stall = 1'b0;
  logic [BW*32-1:0] prev_data;
  bit               exp_done = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (msg_done || exp_done)
        chk(msg_done == exp_done, "R8 msg_done", 512'(msg_done), 512'(exp_done));
      if (msg_done) done_seen++;
      if (wr_err) err_seen++;
      if (prev_stall)
        chk(blk_data == prev_data, "R6 held block", blk_data, prev_data);
      if (blk_valid)
        chk(!wr_ready, "R7 input stalled", 512'(wr_ready), 512'(0));
      exp_done = 1'b0;
      if (blk_valid && blk_ready) begin
        blocks_seen++;
        if (q_data.size() == 0) begin
          chk(1'b0, "R6 unexpected block", 512'(blk_nwords), 512'(0));
        end else begin
          chk(blk_data == q_data[0], "R3 R5 R6 block data", blk_data, q_data[0]);
          chk(int'(blk_nwords) == q_nw[0], "R6 nwords", 512'(blk_nwords), 512'(q_nw[0]));
          chk(int'(blk_tail_bytes) == q_tail[0], "R5 tail bytes",
              512'(blk_tail_bytes), 512'(q_tail[0]));
          chk(blk_last == q_last[0], "R6 last flag", 512'(blk_last), 512'(q_last[0]));
          exp_done = q_last[0];
          void'(q_data.pop_front()); void'(q_nw.pop_front());
          void'(q_tail.pop_front()); void'(q_last.pop_front());
        end
      end
      prev_stall = blk_valid && !blk_ready;
      prev_data  = blk_data;
    end
  end

  task automatic wr_word(input logic [31:0] d, output int stalls);
    bit r = 1'b0;
    stalls = 0;
    wr_valid = 1'b1;
    wr_data  = d;
    while (!r) begin
      @(negedge clk);
      r = wr_ready;
      if (!r) stalls++;
      @(posedge clk); #1;
    end
    wr_valid = 1'b0;
  endtask

  task automatic run_msg(input int mode, input int nbytes, input int junk,
                         input int seed, output int first_stall, output int later_stall);
    int nw = (nbytes + 3) / 4;
    int st;
    if (nw == 0) begin
      q_data.push_back('0); q_nw.push_back(0); q_tail.push_back(0); q_last.push_back(1'b1);
    end
    for (int s = 0; s < nw; s += BW) begin
      logic [BW*32-1:0] d = '0;
      int cnt = (nw - s < BW) ? nw - s : BW;
      bit lst = (s + BW >= nw);
      for (int k = 0; k < cnt; k++) begin
        int keep = (s + k == nw - 1) ? nbytes - 4 * (nw - 1) : 4;
        d[BW*32-1-32*k -: 32] = ref_fmt(gen_word(s + k, seed), mode, keep);
      end
      q_data.push_back(d); q_nw.push_back(cnt);
      q_tail.push_back(lst ? nbytes - 4 * (nw - 1) : 4); q_last.push_back(lst);
    end
    arm = 1'b1; cfg_order = 2'(mode); cfg_bitlen = LEN_W'(nbytes * 8 + junk);
    @(posedge clk); #1;
    arm = 1'b0;
    first_stall = 0; later_stall = 0;
    for (int i = 0; i < nw; i++) begin
      wr_word(gen_word(i, seed), st);
      if (i == 0) first_stall = st; else later_stall += st;
    end
  endtask

  task automatic drain();
    int n = 0;
    while (q_data.size() != 0 && n < 200) begin
      @(posedge clk); #1; n++;
    end
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    int fs, ls, e0, b0, d0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state
    chk(wr_ready == 1'b1, "R1 wr_ready", 512'(wr_ready), 512'(1));
    chk(blk_valid == 1'b0, "R1 blk_valid", 512'(blk_valid), 512'(0));
    chk(msg_done == 1'b0 && wr_err == 1'b0, "R1 pulses", 512'({msg_done, wr_err}), 512'(0));

    // R9: write before any arm
    e0 = err_seen; b0 = blocks_seen;
    wr_word(32'hDEAD_BEEF, fs);
    repeat (2) @(posedge clk);
    #1;
    chk(err_seen == e0 + 1, "R9 error before arm", 512'(err_seen), 512'(e0 + 1));
    chk(blocks_seen == b0, "R9 no block", 512'(blocks_seen), 512'(b0));

    // R2 R4 R5: mode 0, 85 bits -> 10 bytes, early first write
    run_msg(0, 10, 5, 1, fs, ls);
    chk(fs == 2, "R2 settle stalls", 512'(fs), 512'(2));
    drain();

    // R3: the other orders, 8 bytes each
    run_msg(1, 8, 0, 2, fs, ls); drain();
    run_msg(2, 8, 0, 3, fs, ls); drain();
    run_msg(3, 8, 0, 4, fs, ls); drain();

    // R5: final word with 3 and 1 valid bytes
    run_msg(2, 7, 7, 5, fs, ls); drain();
    run_msg(1, 13, 3, 6, fs, ls); drain();

    // R7: 64-byte message, back-to-back acceptance
    d0 = done_seen;
    run_msg(3, 64, 0, 7, fs, ls);
    chk(ls == 0, "R7 burst without stalls", 512'(ls), 512'(0));
    drain();
    chk(done_seen == d0 + 1, "R8 one completion", 512'(done_seen), 512'(d0 + 1));

    // R6: 80 bytes with the core stalled
    blk_ready = 1'b0;
    fork
      run_msg(1, 80, 0, 8, fs, ls);
      begin repeat (30) @(posedge clk); #1 blk_ready = 1'b1; end
    join
    chk(ls > 0, "R7 input held during stall", 512'(ls), 512'(1));
    drain();

    // R9: write after the final word
    e0 = err_seen; b0 = blocks_seen;
    wr_word(32'h1234_5678, fs);
    repeat (3) @(posedge clk);
    #1;
    chk(err_seen == e0 + 1, "R9 error after final", 512'(err_seen), 512'(e0 + 1));
    chk(blocks_seen == b0, "R9 ignored write", 512'(blocks_seen), 512'(b0));

    // R10: zero-length message (junk low bits only)
    d0 = done_seen; b0 = blocks_seen;
    run_msg(0, 0, 6, 9, fs, ls);
    drain();
    chk(blocks_seen == b0 + 1, "R10 empty block", 512'(blocks_seen), 512'(b0 + 1));
    chk(done_seen == d0 + 1, "R10 completion", 512'(done_seen), 512'(d0 + 1));

    chk(q_data.size() == 0, "R6 all blocks delivered", 512'(q_data.size()), 512'(0));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule